// File: doc/BRIEF.md
# Flash Access Mode Controller

This block sits between a CPU and an on-chip flash array. The array and a small bank of flash control registers share one program-space address window. At any time only one of the two is visible. The controller keeps a single mode bit that decides which one answers accesses to the window.

Software changes the mode by touching one reserved I/O location. Any I/O write to that location switches the block to register mode, and the written value does not matter. Any I/O read of it switches the block back to array mode. The reserved location never returns stored data. A read of it answers with zero.

In array mode, window reads go straight to the array read port and the control registers are hidden. In register mode, the array port stays idle. The first window words map to the control registers, and the rest of the window reads as zero and ignores writes.

Top module: `flash_mode_ctrl`

## Requirements
- R1: After reset the block is in array mode, shown as `acc_mode` = 0 (1 means register mode).
- R2: An I/O write with `io_addr` = `MODE_IO_ADDR` (default FF0Fh) puts the block in register mode from the next clock edge on.
- R3: An I/O read of `MODE_IO_ADDR` with no write in the same cycle puts the block in array mode from the next clock edge on. During that read `io_claim` is 1 and `io_rdata` is 0. When read and write strobes arrive together, the write wins.
- R4: I/O reads and writes to any other I/O address leave the mode unchanged.
- R5: In array mode, a window read raises `arr_rd`, presents the offset (`mem_addr` low `WIN_AW` bits) on `arr_addr` and returns `arr_rdata` on `mem_rdata` in the same cycle. Window writes do not change any control register.
- R6: In register mode, window offset k < `NREG` (4) reads and writes control register k. Register k is visible on `ctl_regs[16k+15:16k]` after the write edge. `arr_rd` stays 0.
- R7: In register mode, window offsets from `NREG` up to the window end read as 0 and ignore writes.
- R8: Addresses outside the window (`mem_addr >> WIN_AW` differs from `WIN_BASE >> WIN_AW`) give `mem_hit` = 0 and `mem_rdata` = 0. They touch neither the array port nor the registers.
- R9: An array read and a control-register write never happen in the same cycle.
- R10: All control registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O bus address |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_claim | output | 1 | This block answers the current I/O read |
| io_rdata | output | 16 | I/O read data (always zero) |
| mem_addr | input | 16 | Program-space address |
| mem_rd | input | 1 | Program-space read strobe |
| mem_wr | input | 1 | Program-space write strobe |
| mem_wdata | input | 16 | Program-space write data |
| mem_rdata | output | 16 | Program-space read data |
| mem_hit | output | 1 | Address falls inside the flash window |
| arr_addr | output | 6 | Array word offset |
| arr_rd | output | 1 | Array read enable |
| arr_rdata | input | 16 | Array read data |
| acc_mode | output | 1 | 0 = array mode, 1 = register mode |
| ctl_regs | output | 64 | Control register contents, register k at bits 16k+15:16k |

## Verification
The bench sweeps every window offset in both modes.

- A decoder that leaked the registers into array mode would alter `ctl_regs` on array-mode writes. One that leaked the array into register mode would raise `arr_rd`.
- The gap above the fourth register is probed with all-ones writes. A design that aliased offsets by dropping the upper bits would corrupt a register there, or read back nonzero.
- Near-miss I/O addresses are applied in both directions to catch a loose mode-address decode.
- A combined read-and-write strobe on the mode location is applied to pin down the priority.
- Out-of-window addresses on both sides of the window catch a base compare that drops bits.

// File: rtl/flash_mode_pkg.sv
package flash_mode_pkg;

  typedef enum logic {
    MODE_ARRAY = 1'b0,
    MODE_REGS  = 1'b1
  } acc_mode_e;

  // True when addr falls in the aligned window of 2**aw words at base.
  function automatic logic win_match(input logic [15:0] addr,
                                     input logic [15:0] base,
                                     input int unsigned aw);
    return (addr >> aw) == (base >> aw);
  endfunction

  // True when a window offset selects an implemented control register.
  function automatic logic slot_valid(input logic [15:0] offset,
                                      input int unsigned nreg);
    return 32'(offset) < nreg;
  endfunction

endpackage

// File: rtl/flash_mode_latch.sv
module flash_mode_latch
  import flash_mode_pkg::*;
#(
  parameter int unsigned        IO_AW     = 16,
  parameter logic [IO_AW-1:0]   MODE_ADDR = 16'hFF0F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IO_AW-1:0] io_addr,
  input  logic             io_rd,
  input  logic             io_wr,
  output logic             sel_rd,
  output acc_mode_e        mode
);

  logic hit;
  logic go_regs;
  logic go_array;

  assign hit      = (io_addr == MODE_ADDR);
  assign go_regs  = hit && io_wr;
  assign go_array = hit && io_rd && !io_wr;
  assign sel_rd   = hit && io_rd;

  always_ff @(posedge clk) begin
    if (!rst_n)        mode <= MODE_ARRAY;
    else if (go_regs)  mode <= MODE_REGS;
    else if (go_array) mode <= MODE_ARRAY;
  end

endmodule

// File: rtl/flash_win_decode.sv
module flash_win_decode
  import flash_mode_pkg::*;
#(
  parameter int unsigned     ADDR_W   = 16,
  parameter int unsigned     WIN_AW   = 6,
  parameter logic [15:0]     WIN_BASE = 16'h4000,
  parameter int unsigned     NREG     = 4,
  localparam int unsigned    IDX_W    = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  acc_mode_e         mode,
  output logic              in_win,
  output logic              slot_ok,
  output logic              arr_rd,
  output logic              reg_wr,
  output logic [WIN_AW-1:0] offset,
  output logic [IDX_W-1:0]  reg_idx
);

  assign in_win  = win_match(16'(mem_addr), WIN_BASE, WIN_AW);
  assign offset  = mem_addr[WIN_AW-1:0];
  assign slot_ok = slot_valid(16'(offset), NREG);
  assign reg_idx = offset[IDX_W-1:0];
  assign arr_rd  = in_win && mem_rd && (mode == MODE_ARRAY);
  assign reg_wr  = in_win && mem_wr && (mode == MODE_REGS) && slot_ok;

endmodule

// File: rtl/flash_ctl_regs.sv
module flash_ctl_regs #(
  parameter int unsigned  NREG   = 4,
  parameter int unsigned  DATA_W = 16,
  localparam int unsigned IDX_W  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       idx,
  input  logic [DATA_W-1:0]      wdata,
  output logic [DATA_W-1:0]      rdata,
  output logic [NREG*DATA_W-1:0] q_flat
);

  logic [DATA_W-1:0] q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                            q[g] <= '0;
      else if (wr_en && (32'(idx) == 32'(g))) q[g] <= wdata;
    end
    assign q_flat[g*DATA_W +: DATA_W] = q[g];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (32'(idx) == 32'(i)) rdata = q[i];
  end

endmodule

// File: rtl/flash_mode_ctrl.sv
module flash_mode_ctrl
  import flash_mode_pkg::*;
#(
  parameter int unsigned     ADDR_W       = 16,
  parameter int unsigned     DATA_W       = 16,
  parameter int unsigned     WIN_AW       = 6,
  parameter logic [15:0]     WIN_BASE     = 16'h4000,
  parameter int unsigned     NREG         = 4,
  parameter logic [15:0]     MODE_IO_ADDR = 16'hFF0F
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [15:0]            io_addr,
  input  logic                   io_rd,
  input  logic                   io_wr,
  output logic                   io_claim,
  output logic [DATA_W-1:0]      io_rdata,
  input  logic [ADDR_W-1:0]      mem_addr,
  input  logic                   mem_rd,
  input  logic                   mem_wr,
  input  logic [DATA_W-1:0]      mem_wdata,
  output logic [DATA_W-1:0]      mem_rdata,
  output logic                   mem_hit,
  output logic [WIN_AW-1:0]      arr_addr,
  output logic                   arr_rd,
  input  logic [DATA_W-1:0]      arr_rdata,
  output logic                   acc_mode,
  output logic [NREG*DATA_W-1:0] ctl_regs
);

  localparam int unsigned IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  acc_mode_e         mode;
  logic              mode_regs;
  logic              in_win;
  logic              slot_ok;
  logic              reg_wr;
  logic [WIN_AW-1:0] offset;
  logic [IDX_W-1:0]  reg_idx;
  logic [DATA_W-1:0] reg_rdata;

  flash_mode_latch #(.IO_AW(16), .MODE_ADDR(MODE_IO_ADDR)) u_latch (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd),
    .io_wr(io_wr), .sel_rd(io_claim), .mode(mode)
  );

  flash_win_decode #(.ADDR_W(ADDR_W), .WIN_AW(WIN_AW), .WIN_BASE(WIN_BASE),
                     .NREG(NREG)) u_dec (
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mode(mode),
    .in_win(in_win), .slot_ok(slot_ok), .arr_rd(arr_rd), .reg_wr(reg_wr),
    .offset(offset), .reg_idx(reg_idx)
  );

  flash_ctl_regs #(.NREG(NREG), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .idx(reg_idx),
    .wdata(mem_wdata), .rdata(reg_rdata), .q_flat(ctl_regs)
  );

  assign mode_regs = (mode == MODE_REGS);
  assign acc_mode  = mode_regs;
  assign mem_hit   = in_win;
  assign arr_addr  = offset;
  assign io_rdata  = '0;

  always_comb begin
    mem_rdata = '0;
    if (in_win) begin
      if (!mode_regs)   mem_rdata = arr_rdata;
      else if (slot_ok) mem_rdata = reg_rdata;
    end
  end

endmodule

// File: rtl/flash_mode_chk.sv
module flash_mode_chk #(
  parameter int unsigned DATA_W       = 16,
  parameter logic [15:0] MODE_IO_ADDR = 16'hFF0F
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       io_addr,
  input logic              io_rd,
  input logic              io_wr,
  input logic              mode_regs,
  input logic              arr_rd,
  input logic              reg_wr,
  input logic              mem_hit,
  input logic              mem_rd,
  input logic              slot_ok,
  input logic [DATA_W-1:0] mem_rdata
);

  // R2
  r2_enter_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == MODE_IO_ADDR) |=> mode_regs);

  // R3
  r3_enter_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !io_wr && io_addr == MODE_IO_ADDR) |=> !mode_regs);

  // R4
  r4_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_addr == MODE_IO_ADDR && (io_rd || io_wr)) |=> $stable(mode_regs));

  // R6
  r6_array_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_regs |-> !arr_rd);

  // R7
  r7_gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_regs && mem_hit && mem_rd && !slot_ok) |-> (mem_rdata == '0));

  // R8
  r8_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_hit |-> (!arr_rd && !reg_wr && mem_rdata == '0));

  // R9
  r9_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_rd && reg_wr));

endmodule

bind flash_mode_ctrl flash_mode_chk #(.DATA_W(DATA_W), .MODE_IO_ADDR(MODE_IO_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
  .mode_regs(mode_regs), .arr_rd(arr_rd), .reg_wr(reg_wr), .mem_hit(mem_hit),
  .mem_rd(mem_rd), .slot_ok(slot_ok), .mem_rdata(mem_rdata)
);

// File: tb/tb_flash_mode_ctrl.sv
module tb_flash_mode_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] BASE = 16'h4000;
  localparam logic [15:0] MADDR = 16'hFF0F;
  localparam int WIN = 64;
  localparam int NR = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] io_addr = '0;
  logic        io_rd = 0, io_wr = 0;
  logic        io_claim;
  logic [15:0] io_rdata;
  logic [15:0] mem_addr = '0;
  logic        mem_rd = 0, mem_wr = 0;
  logic [15:0] mem_wdata = '0;
  logic [15:0] mem_rdata;
  logic        mem_hit;
  logic [5:0]  arr_addr;
  logic        arr_rd;
  logic [15:0] arr_rdata;
  logic        acc_mode;
  logic [63:0] ctl_regs;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] shadow [NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] arr_model(input logic [5:0] a);
    return {10'd0, a} * 16'h0301 ^ 16'hA5C3;
  endfunction

  assign arr_rdata = arr_model(arr_addr);

  flash_mode_ctrl dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_claim(io_claim), .io_rdata(io_rdata), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_hit(mem_hit), .arr_addr(arr_addr),
    .arr_rd(arr_rd), .arr_rdata(arr_rdata), .acc_mode(acc_mode),
    .ctl_regs(ctl_regs)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    io_rd = 0; io_wr = 0; mem_rd = 0; mem_wr = 0;
  endtask

  task automatic io_op(input logic rd, input logic wr, input logic [15:0] a);
    @(negedge clk);
    mem_rd = 0; mem_wr = 0;
    io_addr = a; io_rd = rd; io_wr = wr;
    #1;
    if (rd && !wr && a == MADDR) begin
      check("R3 claim", io_claim, 1);
      check("R3 rdata", io_rdata, 0);
    end
    @(posedge clk);
    idle();
  endtask

  task automatic mem_read(input logic [15:0] a, input logic [15:0] exp,
                          input logic exp_arr, input string req);
    @(negedge clk);
    io_rd = 0; io_wr = 0;
    mem_addr = a; mem_rd = 1; mem_wr = 0;
    #1;
    check(req, mem_rdata, exp);
    check({req, " arr_rd"}, arr_rd, exp_arr);
    if (exp_arr) check({req, " arr_addr"}, arr_addr, a[5:0]);
  endtask

  task automatic mem_write(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    io_rd = 0; io_wr = 0;
    mem_addr = a; mem_rd = 0; mem_wr = 1; mem_wdata = d;
    @(posedge clk);
    idle();
  endtask

  task automatic check_regs(input string req);
    for (int k = 0; k < NR; k++) check(req, ctl_regs[k*16 +: 16], shadow[k]);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 50000);
    n_fail++; n_tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < NR; k++) shadow[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    check("R1 reset mode", acc_mode, 0);
    check_regs("R10 reset regs");

    // R5: array mode sweep, registers hidden
    for (int k = 0; k < WIN; k++)
      mem_read(BASE + 16'(k), arr_model(6'(k)), 1, "R5 array read");
    idle();
    for (int k = 0; k < NR + 2; k++) mem_write(BASE + 16'(k), 16'hDEAD);
    check_regs("R5 writes hidden");

    // R4: near-miss I/O addresses
    io_op(0, 1, 16'hFF0E); check("R4 near wr", acc_mode, 0);
    io_op(0, 1, 16'hFF1F); check("R4 near wr2", acc_mode, 0);
    io_op(0, 1, 16'h7F0F); check("R4 near wr3", acc_mode, 0);

    // R2
    io_op(0, 1, MADDR); check("R2 enter regs", acc_mode, 1);
    io_op(1, 0, 16'hFF0E); check("R4 near rd", acc_mode, 1);
    io_op(1, 0, 16'hFF8F); check("R4 near rd2", acc_mode, 1);

    // R6: register read/write
    for (int k = 0; k < NR; k++) begin
      shadow[k] = 16'h1000 + 16'(k) * 16'h0111;
      mem_write(BASE + 16'(k), shadow[k]);
    end
    check_regs("R6 reg write");
    for (int k = 0; k < NR; k++) begin
      mem_read(BASE + 16'(k), shadow[k], 0, "R6 reg read");
      check("R9 no array while reg", arr_rd, 0);
    end
    idle();

    // R7: gap above registers
    for (int k = NR; k < WIN; k++) mem_write(BASE + 16'(k), 16'hFFFF);
    check_regs("R7 gap writes ignored");
    for (int k = NR; k < WIN; k++) mem_read(BASE + 16'(k), 16'h0000, 0, "R7 gap read");
    idle();

    // R8: outside window both sides
    mem_write(BASE - 16'd1, 16'h5555);
    mem_write(BASE + 16'(WIN), 16'h6666);
    mem_write(16'hC000, 16'h7777);
    check_regs("R8 outside writes");
    mem_read(BASE - 16'd1, 0, 0, "R8 outside read lo");
    check("R8 hit lo", mem_hit, 0);
    mem_read(BASE + 16'(WIN), 0, 0, "R8 outside read hi");
    check("R8 hit hi", mem_hit, 0);
    io_op(0, 1, MADDR);
    idle();

    // R3: read of mode location returns to array mode
    io_op(1, 0, MADDR); check("R3 back to array", acc_mode, 0);
    mem_read(BASE + 16'd2, arr_model(6'd2), 1, "R3 array visible");
    mem_read(BASE - 16'd1, 0, 0, "R8 outside in array");
    check("R8 arr_rd outside", arr_rd, 0);
    idle();
    check_regs("R5 regs kept while hidden");

    // R3 priority: simultaneous strobes -> register mode
    io_op(1, 1, MADDR); check("R3 write wins", acc_mode, 1);
    io_op(1, 0, MADDR); check("R3 leave again", acc_mode, 0);

    // R1/R10: reset mid-run
    io_op(0, 1, MADDR);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    for (int k = 0; k < NR; k++) shadow[k] = '0;
    #1;
    check("R1 reset again", acc_mode, 0);
    check_regs("R10 reset again");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule